// File: doc/BRIEF.md
# Registered Rotate-and-Mask Shift Unit

This block performs the fixed-point shift operations of a 64-bit integer datapath. It covers logical left shifts, logical right shifts and arithmetic right shifts, each at word (low 32 bits) and doubleword size. It also provides a combined operation that sign-extends the low word and then shifts it left. The shift amount comes either from a register operand or from an immediate field. Every operation is built the same way: the operand is rotated left, and a contiguous mask then picks the bits that survive. Arithmetic forms fill the positions outside the mask with the sign bit.

The arithmetic right shifts produce a carry flag and a 32-bit copy of it. The carry is set only when the operand is negative and at least one 1 bit was shifted out. When the record bit is set, the unit also produces a condition nibble for the result. Outputs are registered one cycle after a valid input. The carry outputs keep their value until an arithmetic shift writes them. Instruction decode and register writeback lie outside this block.

Top module: `shift_unit`

## Requirements
- R1: While reset is low, and at the first sample after it, `out_valid`, `ca_we`, `cr0_we`, `ca`, `ca32`, `cr0` and `result` are all zero.
- R2: A valid input at a rising edge is reflected on `out_valid`, `result`, `ca`, `ca32`, `ca_we`, `cr0` and `cr0_we` right after that edge. A cycle without `in_valid` gives `out_valid`=0, `ca_we`=0 and `cr0_we`=0, and `result` keeps its previous value.
- R3: The `op` encodings are 0 word left logical (register amount), 1 word right logical (register), 2 word right arithmetic (register), 3 word right arithmetic (immediate), 4 doubleword left logical (register), 5 doubleword right logical (register), 6 doubleword right arithmetic (register), 7 doubleword right arithmetic (immediate), 8 sign-extend word then shift left (immediate). The logical left shifts move the operand toward the MSB and fill with zeros. Word forms act on bits 31:0 and return bits 63:32 as zero.
- R4: The logical right shifts move the operand toward the LSB and fill with zeros. Word forms act on bits 31:0 and zero bits 63:32.
- R5: A register amount uses `amt_reg[4:0]` for word forms and `amt_reg[5:0]` for doubleword forms. If `amt_reg[5]` (word) or `amt_reg[6]` (doubleword) is set, the amount is out of range and logical results are zero. Bits of `amt_reg` above that range bit have no effect.
- R6: Arithmetic right shifts fill the vacated positions with the sign bit. The sign bit is bit 31 for word forms and bit 63 for doubleword forms. A word result is sign-extended to 64 bits, and an out-of-range amount gives all sign bits.
- R7: For arithmetic shifts, `ca` and `ca32` both equal sign AND (any 1 bit shifted out). Word forms look only at the low word. An amount of zero returns the (sign-extended) operand with carry 0.
- R8: Immediate forms take `amt_imm[4:0]` (word) or `amt_imm[5:0]` (doubleword and op 8). They have no out-of-range case and ignore `amt_reg`.
- R9: Op 8 sign-extends bits 31:0 of `src_val` to 64 bits and shifts the result left by `amt_imm[5:0]`, filling with zeros.
- R10: Only ops 2, 3, 6 and 7 write `ca` and `ca32`, and each such write sets `ca_we` for that cycle. All other ops and idle cycles leave `ca` and `ca32` unchanged.
- R11: `cr0_we` is set exactly when the valid input had `rec_en`=1. In that case `cr0` is {result negative, result positive, result zero, `so_in`} from bit 3 down to bit 0, with the result read as signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation select (see R3) |
| src_val | input | 64 | Operand to be shifted |
| amt_reg | input | 64 | Register shift amount operand |
| amt_imm | input | 6 | Immediate shift amount |
| rec_en | input | 1 | Request a condition nibble |
| so_in | input | 1 | Summary overflow copied into the nibble |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Shift result |
| ca | output | 1 | Carry from arithmetic shifts |
| ca32 | output | 1 | 32-bit copy of the carry |
| ca_we | output | 1 | Carry flags written this cycle |
| cr0 | output | 4 | Condition nibble |
| cr0_we | output | 1 | Condition nibble written this cycle |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The bench changes inputs on a falling edge and compares the outputs on the next falling edge, so each comparison sees the register stage that captured that one operation. The carry flags are checked against a bench-held copy that changes only on arithmetic operations, so the hold behaviour is tested after each logical op and each idle cycle. The sweep covers every operation, every amount including out-of-range values, and operands whose upper bits are deliberately set to junk.

// File: rtl/shu_pkg.sv
package shu_pkg;
    localparam int XLEN = 64;
    localparam int HLEN = XLEN / 2;
    localparam int SW   = $clog2(XLEN);

    typedef enum logic [3:0] {
        OP_LL_W   = 4'd0,
        OP_LR_W   = 4'd1,
        OP_AR_W   = 4'd2,
        OP_ARI_W  = 4'd3,
        OP_LL_D   = 4'd4,
        OP_LR_D   = 4'd5,
        OP_AR_D   = 4'd6,
        OP_ARI_D  = 4'd7,
        OP_SXL    = 4'd8
    } shu_op_e;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic            ca;
        logic            ca32;
        logic            ca_we;
        logic [3:0]      cr0;
        logic            cr0_we;
    } shu_state_t;
endpackage

// File: rtl/shu_rotl.sv
module shu_rotl #(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][W-1-S:0], stage[k][W-1 -: S]}
                                   : stage[k];
    end

    assign dout = stage[SW];
endmodule

// File: rtl/shu_mask.sv
module shu_mask #(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic          en,
    input  logic [SW-1:0] lo,
    input  logic [SW-1:0] hi,
    output logic [W-1:0]  m
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign m[i] = en && (int'(lo) <= i) && (i <= int'(hi));
    end
endmodule

// File: rtl/shu_cond.sv
module shu_cond #(
    parameter int W = 64
) (
    input  logic [W-1:0] val,
    input  logic         so,
    output logic [3:0]   nib
);
    logic is_zero;
    assign is_zero = (val == '0);
    assign nib = {val[W-1], !val[W-1] && !is_zero, is_zero, so};
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] amt_reg,
    input  logic [SW-1:0]   amt_imm,
    input  logic            rec_en,
    input  logic            so_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            ca,
    output logic            ca32,
    output logic            ca_we,
    output logic [3:0]      cr0,
    output logic            cr0_we
);
    localparam logic [XLEN-1:0] LOW_WORD = {{HLEN{1'b0}}, {HLEN{1'b1}}};

    shu_state_t st_d, st_q;

    logic            legal_d, word_d, left_d, arith_d, imm_d, ext_d;
    logic [SW-1:0]   n_d;
    logic            oor_d;
    logic [XLEN-1:0] rot_src_d, rot_out_d, mask_d, fill_d, res_d, lost_d;
    logic [SW-1:0]   rot_amt_d, lo_d, hi_d;
    logic            sign_d, carry_d;
    logic [3:0]      nib_d;

    // operation decode
    always_comb begin
        legal_d = 1'b1;
        word_d  = 1'b0;
        left_d  = 1'b0;
        arith_d = 1'b0;
        imm_d   = 1'b0;
        ext_d   = 1'b0;
        unique case (shu_op_e'(op))
            OP_LL_W:  begin word_d = 1'b1; left_d = 1'b1; end
            OP_LR_W:  begin word_d = 1'b1; end
            OP_AR_W:  begin word_d = 1'b1; arith_d = 1'b1; end
            OP_ARI_W: begin word_d = 1'b1; arith_d = 1'b1; imm_d = 1'b1; end
            OP_LL_D:  begin left_d = 1'b1; end
            OP_LR_D:  begin end
            OP_AR_D:  begin arith_d = 1'b1; end
            OP_ARI_D: begin arith_d = 1'b1; imm_d = 1'b1; end
            OP_SXL:   begin ext_d = 1'b1; left_d = 1'b1; imm_d = 1'b1; end
            default:  legal_d = 1'b0;
        endcase
    end

    // amount selection and range flag
    always_comb begin
        if (imm_d) begin
            n_d   = word_d ? {1'b0, amt_imm[SW-2:0]} : amt_imm;
            oor_d = 1'b0;
        end else begin
            n_d   = word_d ? {1'b0, amt_reg[SW-2:0]} : amt_reg[SW-1:0];
            oor_d = word_d ? amt_reg[SW-1] : amt_reg[SW];
        end
    end

    // rotate source, rotate amount and mask bounds
    always_comb begin
        if (ext_d)
            rot_src_d = {{HLEN{src_val[HLEN-1]}}, src_val[HLEN-1:0]};
        else if (word_d)
            rot_src_d = {src_val[HLEN-1:0], src_val[HLEN-1:0]};
        else
            rot_src_d = src_val;
        rot_amt_d = left_d ? n_d : SW'(0) - n_d;
        if (left_d) begin
            lo_d = n_d;
            hi_d = word_d ? SW'(HLEN-1) : SW'(XLEN-1);
        end else begin
            lo_d = '0;
            hi_d = (word_d ? SW'(HLEN-1) : SW'(XLEN-1)) - n_d;
        end
    end

    shu_rotl #(.W(XLEN)) u_rotl (
        .din  (rot_src_d),
        .amt  (rot_amt_d),
        .dout (rot_out_d)
    );

    shu_mask #(.W(XLEN)) u_mask (
        .en (legal_d && !oor_d),
        .lo (lo_d),
        .hi (hi_d),
        .m  (mask_d)
    );

    // merge, sign fill and carry
    always_comb begin
        sign_d  = word_d ? src_val[HLEN-1] : src_val[XLEN-1];
        fill_d  = (arith_d && sign_d) ? '1 : '0;
        res_d   = (rot_out_d & mask_d) | (fill_d & ~mask_d);
        lost_d  = rot_out_d & ~mask_d & (word_d ? LOW_WORD : '1);
        carry_d = arith_d && sign_d && (lost_d != '0);
    end

    shu_cond #(.W(XLEN)) u_cond (
        .val (res_d),
        .so  (so_in),
        .nib (nib_d)
    );

    // next state
    always_comb begin
        st_d        = st_q;
        st_d.vld    = in_valid;
        st_d.ca_we  = 1'b0;
        st_d.cr0_we = 1'b0;
        if (in_valid) begin
            st_d.res = res_d;
            if (arith_d) begin
                st_d.ca    = carry_d;
                st_d.ca32  = carry_d;
                st_d.ca_we = 1'b1;
            end
            if (rec_en) begin
                st_d.cr0    = nib_d;
                st_d.cr0_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign ca        = st_q.ca;
    assign ca32      = st_q.ca32;
    assign ca_we     = st_q.ca_we;
    assign cr0       = st_q.cr0;
    assign cr0_we    = st_q.cr0_we;

    // R2: output valid follows the input one edge later
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R10: carry flags are held unless written
    assert_ca_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ca_we |-> ($stable(ca) && $stable(ca32)));

    // R10: a carry write belongs to a registered operation
    assert_ca_we_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ca_we |-> out_valid);

    // R7: a set carry only comes from a negative operand, so the result is negative
    assert_carry_negative_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ca_we && ca) |-> result[XLEN-1]);

    // R11: nibble write follows the record request
    assert_cr0_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |-> $past(in_valid && rec_en));

    // R11: exactly one of negative, positive, zero
    assert_cr0_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |-> ($countones(cr0[3:1]) == 1));
endmodule

// File: tb/shift_unit_tb.sv
module shift_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] src_val = '0;
    logic [63:0] amt_reg = '0;
    logic [5:0]  amt_imm = '0;
    logic        rec_en = 1'b0;
    logic        so_in = 1'b0;
    logic        out_valid, ca, ca32, ca_we, cr0_we;
    logic [63:0] result;
    logic [3:0]  cr0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic        ca_model = 1'b0;
    logic [63:0] res_model = '0;

    always #10 clk = ~clk;

    shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_val(src_val), .amt_reg(amt_reg), .amt_imm(amt_imm),
        .rec_en(rec_en), .so_in(so_in), .out_valid(out_valid),
        .result(result), .ca(ca), .ca32(ca32), .ca_we(ca_we),
        .cr0(cr0), .cr0_we(cr0_we)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int i);
        case (i % 8)
            0: pat = 64'h0000_0000_0000_0000;
            1: pat = 64'hFFFF_FFFF_FFFF_FFFF;
            2: pat = 64'h8000_0000_0000_0000;
            3: pat = 64'h0000_0000_8000_0001;
            4: pat = 64'h7FFF_FFFF_FFFF_FFFF;
            5: pat = 64'h1234_5678_9ABC_DEF0;
            6: pat = 64'hFEDC_BA98_0765_4321;
            default: pat = 64'h0000_0000_FFFF_FFFF;
        endcase
    endfunction

    // reference model computed with plain shift operators
    task automatic model(input logic [3:0] o, input logic [63:0] s, input logic [63:0] rb,
                         input logic [5:0] im, output logic [63:0] r,
                         output logic arith, output logic cy);
        logic [31:0] w;
        logic [63:0] sw;
        int n;
        bit oor;
        w  = s[31:0];
        sw = {{32{w[31]}}, w};
        arith = (o == 4'd2) || (o == 4'd3) || (o == 4'd6) || (o == 4'd7);
        cy = 1'b0;
        r  = '0;
        case (o)
            4'd0, 4'd1, 4'd2: begin n = int'(rb[4:0]); oor = rb[5]; end
            4'd3:             begin n = int'(im[4:0]); oor = 1'b0; end
            4'd4, 4'd5, 4'd6: begin n = int'(rb[5:0]); oor = rb[6]; end
            default:          begin n = int'(im);      oor = 1'b0; end
        endcase
        case (o)
            4'd0: r = oor ? 64'd0 : {32'd0, w << n};
            4'd1: r = oor ? 64'd0 : {32'd0, w >> n};
            4'd2, 4'd3: begin
                r  = oor ? {64{w[31]}} : 64'($signed(sw) >>> n);
                cy = w[31] && (oor ? (w != 0) : ((w & 32'((64'd1 << n) - 1)) != 0));
            end
            4'd4: r = oor ? 64'd0 : s << n;
            4'd5: r = oor ? 64'd0 : s >> n;
            4'd6, 4'd7: begin
                r  = oor ? {64{s[63]}} : 64'($signed(s) >>> n);
                cy = s[63] && (oor ? (s != 0) : ((s & ((64'd1 << n) - 1)) != 0));
            end
            default: r = sw << n;
        endcase
    endtask

    task automatic run(input logic [3:0] o, input logic [63:0] s, input logic [63:0] rb,
                       input logic [5:0] im, input logic rc, input logic so, input string req);
        logic [63:0] er;
        logic ar, cy;
        logic [3:0] en;
        model(o, s, rb, im, er, ar, cy);
        op = o; src_val = s; amt_reg = rb; amt_imm = im;
        rec_en = rc; so_in = so; in_valid = 1'b1;
        @(negedge clk);
        if (ar) ca_model = cy;
        res_model = er;
        en = {er[63], !er[63] && (er != 0), er == 0, so};
        chk({req, " R2 valid"}, 64'(out_valid), 64'd1);
        chk({req, " result"}, result, er);
        chk("R7 R10 ca", 64'(ca), 64'(ca_model));
        chk("R7 R10 ca32", 64'(ca32), 64'(ca_model));
        chk("R10 ca_we", 64'(ca_we), 64'(ar));
        chk("R11 cr0_we", 64'(cr0_we), 64'(rc));
        if (rc) chk("R11 cr0", 64'(cr0), 64'(en));
    endtask

    task automatic idle();
        in_valid = 1'b0;
        op = 4'd2; src_val = '1; amt_reg = 64'd3; amt_imm = 6'd7;
        @(negedge clk);
        chk("R2 idle valid", 64'(out_valid), 64'd0);
        chk("R2 idle ca_we", 64'(ca_we), 64'd0);
        chk("R2 idle cr0_we", 64'(cr0_we), 64'd0);
        chk("R2 idle result held", result, res_model);
        chk("R10 idle ca held", 64'(ca), 64'(ca_model));
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset result", result, 64'd0);
        chk("R1 reset flags", 64'({ca, ca32, ca_we, cr0_we}), 64'd0);
        chk("R1 reset cr0", 64'(cr0), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 64'({out_valid, ca, ca_we, cr0_we}), 64'd0);

        // register-amount forms: amounts 0..127 with junk upper bits (R3 R4 R5 R6 R7)
        for (int o = 0; o < 7; o++) begin
            if (o == 3) continue;
            for (int p = 0; p < 8; p++) begin
                for (int a = 0; a < 128; a++) begin
                    run(4'(o), pat(p), (pat(p + 3) & ~64'h7F) | 64'(a),
                        6'(a) ^ 6'h2A, 1'((a + p) % 2), 1'(a % 3 == 0),
                        (o == 0 || o == 4) ? "R3 R5" : (o == 1 || o == 5) ? "R4 R5" : "R6 R7");
                end
                idle();
            end
        end

        // immediate forms: amounts 0..63, register amount is junk (R8 R9)
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < 8; p++) begin
                for (int a = 0; a < 64; a++) begin
                    run((k == 0) ? 4'd3 : (k == 1) ? 4'd7 : 4'd8, pat(p), pat(p + 5) | 64'h60,
                        6'(a), 1'(a % 2), 1'(p % 2), (k == 2) ? "R9" : "R8 R7");
                end
                idle();
            end
        end

        // explicit corner: negative word shifted by 1 loses a one -> carry (R7)
        run(4'd2, 64'h0000_0000_8000_0001, 64'd1, 6'd0, 1'b1, 1'b0, "R7 corner");
        chk("R7 corner carry", 64'(ca), 64'd1);
        // logical op afterwards keeps carry (R10)
        run(4'd4, 64'd5, 64'd2, 6'd0, 1'b0, 1'b0, "R10 hold");
        chk("R10 carry held", 64'(ca), 64'd1);

        done = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual running expected finished");
            report();
        end
    end
endmodule